// File: doc/BRIEF.md
# Bus Cycle Definition Driver

This block produces the three cycle-definition outputs of a processor bus interface and decides, cycle by cycle, whether they are driven or left floating. The three outputs are: data-or-code (high = data), memory-or-I/O (high = memory) and write-or-read (high = write). Which unit issued the access sets the data-or-code value. An access from the prefetch or branch unit is code, and an access from the load/store unit is data. Two requests override the normal encoding: an interrupt-acknowledge request and a special-cycle request. A code read from I/O space is refused, because its encoding is the same as the interrupt-acknowledge encoding.

The bus controller presents a request together with the address strobe and an expected beat count. The outputs are driven from that strobe clock up to and including the clock that carries the last expected burst-ready. Several system controls can float the outputs: back-off, hold-acknowledge, bus reset, init, address-hold and the power states. A cycle cut short by back-off is kept. It is replayed on the next accepted strobe with its original encoding and its full beat count. Each output has its own enable. While the enables are low, the value outputs keep their last values.

Top module: `bus_cycdef_drv`

## Requirements
- R1: In the strobe clock of an accepted ordinary request, the three enables go high together and the outputs show data-or-code = NOT req_code_i, memory-or-I/O = req_mem_i and write-or-read = req_write_i.
- R2: An accepted interrupt-acknowledge request drives 0,0,0 and an accepted special-cycle request drives 0,0,1 (order data-or-code, memory-or-I/O, write-or-read). Interrupt-acknowledge takes priority over special cycle, and special cycle takes priority over an ordinary request.
- R3: An ordinary code request that is an I/O read raises req_rej_o in its strobe clock. No cycle starts, and the enables stay low unless an earlier cycle is still running.
- R4: A cycle with beat count N (a count of 0 counts as 1) keeps the enables high through the clock of its N-th burst-ready and drops them in the next clock. Burst-ready is counted only after the strobe clock.
- R5: In the clock where back-off is first seen high, the outputs are still driven. They float from the next clock onward, and they stay floated through the clock after back-off falls.
- R6: A cycle running when back-off is sampled is aborted. The next accepted strobe replays its encoding and its beat count and ignores the request inputs.
- R7: Hold-acknowledge floats the outputs in the same clock it is asserted, and a strobe presented during it is ignored.
- R8: Bus reset or init floats the outputs in the same clock and clears any running or pending cycle. After the active-low asynchronous reset, all enables are low.
- R9: In the stop-clock power state the outputs are floated and strobes are ignored.
- R10: While address-hold is high, a cycle already running keeps driving. A new strobe starts a cycle only if it is an inquire writeback.
- R11: In the halt, shutdown and stop-grant states only inquire-writeback cycles start or drive. Power state codes: 0 run, 1 halt, 2 shutdown, 3 stop grant, 4 stop clock.
- R12: While floated, the value outputs hold the values they last had.
- R13: The three enables are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ads_i | input | 1 | Address strobe; starts a cycle |
| req_code_i | input | 1 | 1 = request from prefetch/branch, 0 = from load/store |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_write_i | input | 1 | 1 = write, 0 = read |
| spec_req_i | input | 1 | Special-cycle request |
| inta_req_i | input | 1 | Interrupt-acknowledge request |
| beats_i | input | BEAT_W | Expected burst-ready count for the cycle |
| brdy_i | input | 1 | Burst-ready |
| boff_i | input | 1 | Back-off from system logic |
| hlda_i | input | 1 | Hold-acknowledge |
| ahold_i | input | 1 | Address-hold |
| bus_reset_i | input | 1 | Bus reset (float, clear) |
| init_i | input | 1 | Init (float, clear) |
| inq_wb_i | input | 1 | Strobed cycle is an inquire writeback |
| pwr_state_i | input | 3 | Power state code |
| dc_o | output | 1 | Data-or-code value |
| mio_o | output | 1 | Memory-or-I/O value |
| wr_o | output | 1 | Write-or-read value |
| dc_oe_o | output | 1 | Enable for dc_o |
| mio_oe_o | output | 1 | Enable for mio_o |
| wr_oe_o | output | 1 | Enable for wr_o |
| req_rej_o | output | 1 | Illegal I/O code read refused |

## Verification
The strobe encoding, the refusal flag and the hold-acknowledge, reset and init floating are combinational, so they are due in the same clock as their input. The end of a cycle and the back-off float are each due one clock after the edge that samples the last burst-ready or the back-off. Inputs change on the falling edge. One time unit later, the bench compares the outputs against a model that it advances only at the rising edge, so each result is compared in exactly the clock in which it is due.

// File: rtl/cycdef_pkg.sv
package cycdef_pkg;
  typedef enum logic [2:0] {
    PWR_RUN      = 3'd0,
    PWR_HALT     = 3'd1,
    PWR_SHUTDOWN = 3'd2,
    PWR_STOPGNT  = 3'd3,
    PWR_STOPCLK  = 3'd4
  } pwr_e;

  typedef struct packed {
    logic dc;
    logic mio;
    logic wr;
  } cyc_enc_t;

  localparam int unsigned NUM_DEF = 3;
endpackage

// File: rtl/cycdef_encoder.sv
module cycdef_encoder
  import cycdef_pkg::*;
(
  input  logic     src_code_i,
  input  logic     mem_i,
  input  logic     write_i,
  input  logic     spec_i,
  input  logic     inta_i,
  output cyc_enc_t enc_o,
  output logic     illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    if (inta_i) begin
      enc_o = '{dc: 1'b0, mio: 1'b0, wr: 1'b0};
    end else if (spec_i) begin
      enc_o = '{dc: 1'b0, mio: 1'b0, wr: 1'b1};
    end else begin
      enc_o = '{dc: ~src_code_i, mio: mem_i, wr: write_i};
      // code read from I/O would alias interrupt acknowledge
      illegal_o = src_code_i & ~mem_i & ~write_i;
    end
  end
endmodule

// File: rtl/cycdef_gate.sv
module cycdef_gate
  import cycdef_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boff_i,
  input  logic       hlda_i,
  input  logic       bus_reset_i,
  input  logic       init_i,
  input  logic       ahold_i,
  input  logic [2:0] pwr_i,
  input  logic       inq_start_i,
  input  logic       inq_cyc_i,
  output logic       start_ok_o,
  output logic       drive_ok_o
);
  logic boff_q;
  logic hard_off;
  logic pwr_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boff_q <= 1'b0;
    else         boff_q <= boff_i;
  end

  assign pwr_run  = (pwr_i == PWR_RUN);
  assign hard_off = hlda_i | bus_reset_i | init_i | (pwr_i == PWR_STOPCLK) | boff_q;

  assign drive_ok_o = ~hard_off & (pwr_run | inq_cyc_i);
  assign start_ok_o = ~hard_off & ~boff_i & ((pwr_run & ~ahold_i) | inq_start_i);
endmodule

// File: rtl/cycdef_beat_ctr.sv
module cycdef_beat_ctr #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              brdy_i,
  output logic              active_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic              active_q;
  logic [BEAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i && active_q) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= (beats_i == '0) ? ONE : beats_i;
    end else if (active_q && brdy_i) begin
      if (cnt_q == ONE) active_q <= 1'b0;
      cnt_q <= cnt_q - ONE;
    end
  end

  assign active_o = active_q;

  assert_cnt_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));

  assert_last_beat_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && brdy_i && cnt_q == ONE && !clr_i && !abort_i) |=> !active_q);

  assert_abort_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && abort_i) |=> !active_q);
endmodule

// File: rtl/bus_cycdef_drv.sv
module bus_cycdef_drv
  import cycdef_pkg::*;
#(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_i,
  input  logic              req_code_i,
  input  logic              req_mem_i,
  input  logic              req_write_i,
  input  logic              spec_req_i,
  input  logic              inta_req_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              brdy_i,
  input  logic              boff_i,
  input  logic              hlda_i,
  input  logic              ahold_i,
  input  logic              bus_reset_i,
  input  logic              init_i,
  input  logic              inq_wb_i,
  input  logic [2:0]        pwr_state_i,
  output logic              dc_o,
  output logic              mio_o,
  output logic              wr_o,
  output logic              dc_oe_o,
  output logic              mio_oe_o,
  output logic              wr_oe_o,
  output logic              req_rej_o
);
  cyc_enc_t          req_enc, enc_q, new_enc, out_enc;
  logic              req_ill, ill_eff;
  logic [BEAT_W-1:0] beats_q, new_beats;
  logic              inq_q, new_inq, pend_q;
  logic              clr, start, start_ok, drive_ok, active, oe;

  cycdef_encoder u_enc (
    .src_code_i (req_code_i),
    .mem_i      (req_mem_i),
    .write_i    (req_write_i),
    .spec_i     (spec_req_i),
    .inta_i     (inta_req_i),
    .enc_o      (req_enc),
    .illegal_o  (req_ill)
  );

  // replay of a backed-off cycle overrides the request inputs
  assign new_enc   = pend_q ? enc_q   : req_enc;
  assign new_beats = pend_q ? beats_q : beats_i;
  assign new_inq   = pend_q ? inq_q   : inq_wb_i;
  assign ill_eff   = ~pend_q & req_ill;
  assign clr       = bus_reset_i | init_i;

  cycdef_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boff_i      (boff_i),
    .hlda_i      (hlda_i),
    .bus_reset_i (bus_reset_i),
    .init_i      (init_i),
    .ahold_i     (ahold_i),
    .pwr_i       (pwr_state_i),
    .inq_start_i (new_inq),
    .inq_cyc_i   (inq_q),
    .start_ok_o  (start_ok),
    .drive_ok_o  (drive_ok)
  );

  assign start = ads_i & start_ok & ~active & ~ill_eff;

  cycdef_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .abort_i  (boff_i),
    .start_i  (start),
    .beats_i  (new_beats),
    .brdy_i   (brdy_i),
    .active_o (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q   <= '0;
      beats_q <= '0;
      inq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (clr) begin
      pend_q  <= 1'b0;
    end else if (start) begin
      enc_q   <= new_enc;
      beats_q <= new_beats;
      inq_q   <= new_inq;
      pend_q  <= 1'b0;
    end else if (boff_i && active) begin
      pend_q  <= 1'b1;
    end
  end

  assign out_enc   = start ? new_enc : enc_q;
  assign oe        = start | (active & drive_ok);
  assign req_rej_o = ads_i & ill_eff;

  logic [NUM_DEF-1:0] sig_w, en_w;
  for (genvar g = 0; g < int'(NUM_DEF); g++) begin : g_def
    assign sig_w[g] = out_enc[g];
    assign en_w[g]  = oe;
  end

  assign dc_o     = sig_w[2];
  assign mio_o    = sig_w[1];
  assign wr_o     = sig_w[0];
  assign dc_oe_o  = en_w[2];
  assign mio_oe_o = en_w[1];
  assign wr_oe_o  = en_w[0];

  assert_oe_equal_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_oe_o == mio_oe_o) && (mio_oe_o == wr_oe_o));

  assert_reject_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rej_o && !active) |-> !dc_oe_o);

  assert_boff_late_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boff_i |=> !dc_oe_o);

  assert_hlda_float_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_i |-> !dc_oe_o);

  assert_clr_float_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_reset_i || init_i) |-> !dc_oe_o);

  assert_stopclk_float_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == PWR_STOPCLK) |-> !dc_oe_o);

  assert_float_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dc_oe_o && !$past(dc_oe_o)) |-> $stable({dc_o, mio_o, wr_o}));
endmodule

// File: tb/tb_bus_cycdef_drv.sv
module tb_bus_cycdef_drv;
  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W     = 3;

  logic clk, rst_ni;
  logic ads, rcode, rmem, rwr, spec, inta, brdy, boff, hlda, ahold, brst, init, inq;
  logic [BEAT_W-1:0] beats;
  logic [2:0] pwr;
  logic dc, mio, wr, dc_oe, mio_oe, wr_oe, rej;

  bus_cycdef_drv #(.BEAT_W(BEAT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ads_i(ads), .req_code_i(rcode), .req_mem_i(rmem),
    .req_write_i(rwr), .spec_req_i(spec), .inta_req_i(inta), .beats_i(beats),
    .brdy_i(brdy), .boff_i(boff), .hlda_i(hlda), .ahold_i(ahold),
    .bus_reset_i(brst), .init_i(init), .inq_wb_i(inq), .pwr_state_i(pwr),
    .dc_o(dc), .mio_o(mio), .wr_o(wr), .dc_oe_o(dc_oe), .mio_oe_o(mio_oe),
    .wr_oe_o(wr_oe), .req_rej_o(rej)
  );

  int unsigned n_cmp = 0, n_bad = 0;
  string cur_tag = "R8";

  // reference state
  logic m_active, m_pend, m_inq, m_boffq;
  logic [2:0] m_enc;
  logic [BEAT_W-1:0] m_cnt, m_beats;
  logic e_start, e_inq;
  logic [2:0] e_enc;
  logic [BEAT_W-1:0] e_beats;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // R1/R2 encoding {dc,mio,wr}
  function automatic logic [2:0] ref_enc(logic c, logic m, logic w, logic s, logic ia);
    if (ia) return 3'b000;
    if (s)  return 3'b001;
    return {~c, m, w};
  endfunction

  task automatic chk(string what, logic [2:0] act, logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", cur_tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ads = 0; rcode = 0; rmem = 1; rwr = 0; spec = 0; inta = 0; beats = 1;
    brdy = 0; boff = 0; hlda = 0; ahold = 0; brst = 0; init = 0; inq = 0; pwr = 0;
  endtask

  task automatic step();
    logic ill, hard, ok, drv, e_oe, e_rej;
    #1;
    ill     = ~m_pend & ~inta & ~spec & rcode & ~rmem & ~rwr;
    e_enc   = m_pend ? m_enc : ref_enc(rcode, rmem, rwr, spec, inta);
    e_beats = m_pend ? m_beats : beats;
    e_inq   = m_pend ? m_inq : inq;
    hard    = hlda | brst | init | (pwr == 3'd4) | m_boffq;
    ok      = ~hard & ~boff & (((pwr == 3'd0) & ~ahold) | e_inq);
    drv     = ~hard & ((pwr == 3'd0) | m_inq);
    e_start = ads & ok & ~m_active & ~ill;
    e_oe    = e_start | (m_active & drv);
    e_rej   = ads & ill;
    chk("enables", {dc_oe, mio_oe, wr_oe}, {3{e_oe}});
    chk("values", {dc, mio, wr}, e_start ? e_enc : m_enc);
    chk("reject", {2'b00, rej}, {2'b00, e_rej});
    @(posedge clk);
    if (brst | init) begin
      m_active = 0; m_cnt = 0; m_pend = 0;
    end else if (boff & m_active) begin
      m_active = 0; m_cnt = 0; m_pend = 1;
    end else if (e_start) begin
      m_active = 1; m_cnt = (e_beats == 0) ? 1 : e_beats;
      m_enc = e_enc; m_beats = e_beats; m_inq = e_inq; m_pend = 0;
    end else if (m_active & brdy) begin
      if (m_cnt == 1) m_active = 0;
      m_cnt = m_cnt - 1;
    end
    m_boffq = boff;
    @(negedge clk);
  endtask

  task automatic strobe(logic c, logic m, logic w, logic [BEAT_W-1:0] n);
    ads = 1; rcode = c; rmem = m; rwr = w; beats = n;
    step();
    ads = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7051));
    idle();
    rst_ni = 0;
    m_active = 0; m_pend = 0; m_inq = 0; m_boffq = 0; m_enc = 0; m_cnt = 0; m_beats = 0;
    repeat (3) @(negedge clk);
    cur_tag = "R8"; // reset state: enables low
    #1;
    chk("enables", {dc_oe, mio_oe, wr_oe}, 3'b000);
    rst_ni = 1;
    @(negedge clk);

    cur_tag = "R1"; // data memory write, single beat
    strobe(0, 1, 1, 1);
    brdy = 1; step(); brdy = 0;
    cur_tag = "R4"; step();
    cur_tag = "R1"; // code memory read
    strobe(1, 1, 0, 1);
    brdy = 1; step(); brdy = 0; step();

    cur_tag = "R2"; // inta beats special beats ordinary
    inta = 1; spec = 1; strobe(0, 1, 1, 1); inta = 0;
    brdy = 1; step(); brdy = 0;
    strobe(0, 1, 1, 1); spec = 0;
    brdy = 1; step(); brdy = 0; step();

    cur_tag = "R3"; // illegal I/O code read
    strobe(1, 0, 0, 1);
    step();

    cur_tag = "R4"; // burst of 4 with gaps
    strobe(0, 1, 0, 4);
    for (int i = 0; i < 6; i++) begin brdy = (i != 2); step(); end
    brdy = 0;
    strobe(0, 1, 0, 0); // zero counts as one
    brdy = 1; step(); brdy = 0; step();

    cur_tag = "R5"; // back-off mid burst
    strobe(1, 1, 0, 4);
    brdy = 1; step(); brdy = 0;
    boff = 1; step(); step(); step(); boff = 0;
    step();
    cur_tag = "R6"; // replay ignores new request fields
    strobe(0, 0, 1, 1);
    brdy = 1;
    for (int i = 0; i < 5; i++) step();
    brdy = 0;

    cur_tag = "R7";
    strobe(0, 1, 1, 4);
    hlda = 1; step(); ads = 1; step(); ads = 0; hlda = 0;
    brdy = 1; repeat (4) step(); brdy = 0;

    cur_tag = "R8"; // init clears running cycle
    strobe(0, 1, 1, 4);
    init = 1; step(); init = 0; step();

    cur_tag = "R9";
    pwr = 3'd4; strobe(0, 1, 1, 1); step(); pwr = 0;

    cur_tag = "R10";
    strobe(0, 1, 0, 2);
    ahold = 1; brdy = 1; step(); step(); brdy = 0;
    strobe(0, 1, 1, 1);
    inq = 1; strobe(0, 1, 1, 1); inq = 0; ahold = 0;
    brdy = 1; step(); brdy = 0;

    cur_tag = "R11";
    pwr = 3'd1; strobe(0, 1, 1, 1);
    inq = 1; strobe(0, 1, 1, 4); inq = 0;
    pwr = 3'd3; brdy = 1; repeat (4) step(); brdy = 0;
    pwr = 0; strobe(0, 1, 0, 4);
    pwr = 3'd2; step(); step(); pwr = 0;
    brdy = 1; repeat (4) step(); brdy = 0;

    cur_tag = "R12"; // floated values hold
    repeat (3) step();

    for (int i = 0; i < 4000; i++) begin
      ads   = ($urandom_range(99) < 30);
      rcode = $urandom_range(1); rmem = $urandom_range(1); rwr = $urandom_range(1);
      spec  = ($urandom_range(99) < 8);
      inta  = ($urandom_range(99) < 8);
      beats = ($urandom_range(9) == 0) ? 3'd0 : ($urandom_range(1) ? 3'd4 : 3'd1);
      brdy  = ($urandom_range(99) < 50);
      boff  = ($urandom_range(99) < 4);
      hlda  = ($urandom_range(99) < 3);
      ahold = ($urandom_range(99) < 5);
      brst  = ($urandom_range(199) == 0);
      init  = ($urandom_range(199) == 0);
      inq   = ($urandom_range(99) < 20);
      pwr   = ($urandom_range(99) < 6) ? 3'($urandom_range(4)) : 3'd0;
      if (hlda) cur_tag = "R7";
      else if (boff || m_boffq) cur_tag = "R5";
      else if (brst || init) cur_tag = "R8";
      else if (pwr != 0) cur_tag = "R11";
      else if (ahold) cur_tag = "R10";
      else if (m_pend) cur_tag = "R6";
      else cur_tag = "R13";
      step();
    end
    idle();
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule